// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits in front of the per-CPU private peripherals of a four-processor cluster. It decodes a 4 KB window and sends each access to one of three places. The first is a small snoop-control bank that it holds itself. The second is the CPU interface of the interrupt controller. The third is the set of per-CPU timer and watchdog pairs. The interrupt controller and the timers live outside the block. The decoder gives them a select, the CPU they serve, and the offset within their register set. Their read data comes back through input ports.

Two kinds of window reach the interrupt interface and the timers. A banked alias window resolves to whichever CPU issued the access. A row of explicit windows, 256 bytes apart, names each CPU directly. Inside a timer window, one address bit picks the watchdog over the timer. The decoder derives the flat timer index and the private interrupt number (29 or 30) that the selected instance raises. Offsets the block does not map raise an error flag. The one exception is a write above the timer area, which is silently dropped.

Top module: `priv_window_decoder`

## Requirements
- R1: Only address bits 11:0 take part in decoding. Any value on the upper address bits gives the same selects, CPU index, offsets and read data.
- R2: Offset 0x000 holds a one-bit control flag that reset clears. A write stores write-data bit 0 only. A read returns the flag in bit 0, with every other bit zero.
- R3: Offset 0x004 reads as 0x000000F3, and offsets 0x008 and 0x00C read as zero. A write to 0x00C raises no error and leaves the control flag unchanged.
- R4: In the bank below 0x100, the error flag is raised in three cases: any access to an offset other than 0x000/0x004/0x008/0x00C, and any write to 0x004 or 0x008. An erroring read returns zero.
- R5: Offsets 0x100 to 0x1FF select the interrupt interface. The target CPU equals the requesting CPU, and the sub-offset equals address bits 7:0.
- R6: Offsets 0x200 to 0x5FF select the interrupt interface. The target CPU is (offset - 0x200) >> 8, and the sub-offset is address bits 7:0.
- R7: Offsets 0x600 to 0x6FF select the timers of the requesting CPU. Offsets 0x700 to 0xAFF select the timers of CPU (offset - 0x700) >> 8.
- R8: In a timer window, the timer index is target CPU × 2 plus address bit 5 (0 = timer, 1 = watchdog). The timer register offset is address bits 3:0.
- R9: The private interrupt number is 29 for a timer (index bit 0 = 0) and 30 for a watchdog (index bit 0 = 1). The target CPU output equals the index shifted right by one.
- R10: A read at offset 0xB00 or above raises the error flag and returns zero. A write there raises no error, selects no target, and leaves the control flag unchanged.
- R11: Read data appears combinationally, in the same cycle as the read strobe. It comes from the bank, the interrupt read-data input or the timer read-data input, whichever is selected. With no read strobe it is zero.
- R12: The interrupt and timer selects are active only while a read or write strobe is active, and at most one target is selected at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Access address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the CPU issuing the access |
| irqc_rdata | input | 32 | Read data from the interrupt CPU interface |
| tmr_rdata | input | 32 | Read data from the timer set |
| irqc_sel | output | 1 | Interrupt CPU interface selected |
| tmr_sel | output | 1 | Timer set selected |
| tgt_cpu | output | 2 | CPU served by the selected target |
| sub_off | output | 8 | Offset within the interrupt interface window |
| tmr_idx | output | 3 | Flat timer/watchdog index |
| tmr_reg | output | 4 | Register offset within the timer instance |
| tmr_ppi | output | 5 | Private interrupt number of the selected instance |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Access to an unmapped offset |

## Verification
The bench builds the decoder with its defaults: four CPUs, a 32-bit address and a 32-bit data path. These values bring every window boundary within reach. That covers the alias pages, the first and last explicit page of both rows, and the first unmapped page at 0xB00. Each of these is driven from several requesting CPUs, with junk on the upper address bits, so that alias resolution and explicit indexing give different answers. Bank writes are followed by readback at the ports. This exposes any write that should have been dropped but changed the control flag.

// File: rtl/priv_dec_pkg.sv
// Shared types for the private window decoder.
// Assumes: the window is 4 KB, split into 256-byte pages.
package priv_dec_pkg;
    typedef enum logic [1:0] {
        TGT_BANK = 2'd0,
        TGT_IRQC = 2'd1,
        TGT_TMR  = 2'd2,
        TGT_HOLE = 2'd3
    } tgt_e;

    localparam int WIN_W  = 12;
    localparam int PAGE_W = 4;
endpackage

// File: rtl/priv_page_decode.sv
// Page decoder: classifies a 12-bit window offset into a target and resolves
// which CPU it serves (banked alias -> requester, explicit page -> page index).
// Assumes: 3 + 2*NUM_CPU pages fit into the 16 pages of the window.
module priv_page_decode
    import priv_dec_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = $clog2(NUM_CPU)
) (
    input  logic [WIN_W-1:0] win_off,
    input  logic [CPU_W-1:0] req_cpu,
    output tgt_e             tgt,
    output logic [CPU_W-1:0] cpu
);
    localparam int P_IRQC_ALIAS = 1;
    localparam int P_IRQC_BASE  = 2;
    localparam int P_TMR_ALIAS  = P_IRQC_BASE + NUM_CPU;
    localparam int P_TMR_BASE   = P_TMR_ALIAS + 1;
    localparam int P_END        = P_TMR_BASE + NUM_CPU;

    logic [PAGE_W:0] page;
    logic [PAGE_W:0] rel_irqc;
    logic [PAGE_W:0] rel_tmr;

    assign page     = {1'b0, win_off[WIN_W-1 -: PAGE_W]};
    assign rel_irqc = page - (PAGE_W+1)'(P_IRQC_BASE);
    assign rel_tmr  = page - (PAGE_W+1)'(P_TMR_BASE);

    // Pick the target region and the CPU it addresses.
    always_comb begin
        tgt = TGT_HOLE;
        cpu = '0;
        if (page == '0) begin
            tgt = TGT_BANK;
        end else if (page == (PAGE_W+1)'(P_IRQC_ALIAS)) begin
            tgt = TGT_IRQC;
            cpu = req_cpu;
        end else if (page < (PAGE_W+1)'(P_TMR_ALIAS)) begin
            tgt = TGT_IRQC;
            cpu = rel_irqc[CPU_W-1:0];
        end else if (page == (PAGE_W+1)'(P_TMR_ALIAS)) begin
            tgt = TGT_TMR;
            cpu = req_cpu;
        end else if (page < (PAGE_W+1)'(P_END)) begin
            tgt = TGT_TMR;
            cpu = rel_tmr[CPU_W-1:0];
        end
    end
endmodule

// File: rtl/priv_ctl_bank.sv
// Snoop-control register bank: one writable flag, one constant word, two
// zero words; flags any other offset, and writes to read-only words.
// Assumes: read and write strobes are not active together.
module priv_ctl_bank #(
    parameter int         DATA_W  = 32,
    parameter logic [7:0] CFG_VAL = 8'hF3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        off,
    input  logic              wbit,
    output logic [DATA_W-1:0] rdata,
    output logic              bad
);
    localparam logic [7:0] O_CTL = 8'h00;
    localparam logic [7:0] O_CFG = 8'h04;
    localparam logic [7:0] O_STS = 8'h08;
    localparam logic [7:0] O_INV = 8'h0C;

    logic ctl_q;
    logic rd_ok;
    logic wr_ok;

    // Control flag: cleared by reset, loaded from write data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= 1'b0;
        else if (hit && wr && off == O_CTL)
            ctl_q <= wbit;
    end

    // Legal offsets per direction and the read value.
    always_comb begin
        rd_ok = (off == O_CTL) || (off == O_CFG) || (off == O_STS) || (off == O_INV);
        wr_ok = (off == O_CTL) || (off == O_INV);
        rdata = '0;
        if (off == O_CTL)
            rdata[0] = ctl_q;
        else if (off == O_CFG)
            rdata[7:0] = CFG_VAL;
    end

    // Error when the bank is hit at a location illegal for the direction.
    assign bad = hit && ((rd && !rd_ok) || (wr && !wr_ok));

    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && wr && off == O_CTL) |=> $stable(ctl_q));
    assert_ctl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (off == O_CTL) |-> (rdata[DATA_W-1:1] == '0));
    assert_zero_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (off == O_STS || off == O_INV) |-> (rdata == '0));
endmodule

// File: rtl/priv_tmr_route.sv
// Timer routing: forms the flat timer index, the register offset and the
// private interrupt number of the selected timer or watchdog.
// Assumes: address bit 5 picks the watchdog.
module priv_tmr_route #(
    parameter int NUM_CPU  = 4,
    parameter int CPU_W    = $clog2(NUM_CPU),
    parameter int PPI_BASE = 29
) (
    input  logic [CPU_W-1:0] cpu,
    input  logic             wd_bit,
    input  logic [3:0]       reg_in,
    output logic [CPU_W:0]   idx,
    output logic [3:0]       reg_off,
    output logic [4:0]       ppi
);
    // Index, offset and interrupt number are plain recombinations of fields.
    always_comb begin
        idx     = {cpu, wd_bit};
        reg_off = reg_in;
        ppi     = 5'(PPI_BASE) + {4'b0, idx[0]};
    end
endmodule

// File: rtl/priv_window_decoder.sv
// Private window decoder top: steers each access to the control bank, the
// interrupt CPU interface or the timer set, muxes read data, flags holes.
// Assumes: one access per cycle, read data returned in the strobe cycle.
module priv_window_decoder
    import priv_dec_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [DATA_W-1:0] irqc_rdata,
    input  logic [DATA_W-1:0] tmr_rdata,
    output logic              irqc_sel,
    output logic              tmr_sel,
    output logic [CPU_W-1:0]  tgt_cpu,
    output logic [7:0]        sub_off,
    output logic [CPU_W:0]    tmr_idx,
    output logic [3:0]        tmr_reg,
    output logic [4:0]        tmr_ppi,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);
    logic [WIN_W-1:0]  win_off;
    tgt_e              tgt;
    logic [CPU_W-1:0]  dec_cpu;
    logic              acc;
    logic              bank_hit;
    logic              bank_bad;
    logic [DATA_W-1:0] bank_rdata;

    assign win_off = bus_addr[WIN_W-1:0];
    assign acc     = bus_rd || bus_wr;

    priv_page_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_page (
        .win_off (win_off),
        .req_cpu (req_cpu),
        .tgt     (tgt),
        .cpu     (dec_cpu)
    );

    assign bank_hit = (tgt == TGT_BANK);

    priv_ctl_bank #(.DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (bank_hit),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .off   (win_off[7:0]),
        .wbit  (bus_wdata[0]),
        .rdata (bank_rdata),
        .bad   (bank_bad)
    );

    priv_tmr_route #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_tmr (
        .cpu     (dec_cpu),
        .wd_bit  (win_off[5]),
        .reg_in  (win_off[3:0]),
        .idx     (tmr_idx),
        .reg_off (tmr_reg),
        .ppi     (tmr_ppi)
    );

    // Target selects, forwarded CPU and sub-offset.
    always_comb begin
        irqc_sel = acc && (tgt == TGT_IRQC);
        tmr_sel  = acc && (tgt == TGT_TMR);
        tgt_cpu  = dec_cpu;
        sub_off  = win_off[7:0];
    end

    // Read data mux: zero unless a read strobe is active.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (tgt)
                TGT_BANK: bus_rdata = bank_rdata;
                TGT_IRQC: bus_rdata = irqc_rdata;
                TGT_TMR:  bus_rdata = tmr_rdata;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Error: bad bank location, or a read beyond the timer area.
    assign bus_err = bank_bad || (bus_rd && tgt == TGT_HOLE);

    assert_one_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irqc_sel, tmr_sel, acc && bank_hit}));
    assert_sel_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irqc_sel || tmr_sel) |-> acc);
    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
    assert_hole_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && tgt == TGT_HOLE) |-> (!bus_err && !irqc_sel && !tmr_sel));
    assert_ppi_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_sel |-> (tmr_ppi == 5'd29 || tmr_ppi == 5'd30));
    assert_idx_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_sel |-> (tmr_idx[CPU_W:1] == tgt_cpu));
endmodule

// File: tb/priv_window_decoder_bench.sv
`timescale 1ns/1ps
module priv_window_decoder_bench;
    localparam logic [31:0] IRQC_WORD = 32'hA5A5_0001;
    localparam logic [31:0] TMR_WORD  = 32'h5A5A_0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  req_cpu = '0;
    logic [31:0] irqc_rdata = IRQC_WORD;
    logic [31:0] tmr_rdata = TMR_WORD;
    logic        irqc_sel, tmr_sel, bus_err;
    logic [1:0]  tgt_cpu;
    logic [7:0]  sub_off;
    logic [2:0]  tmr_idx;
    logic [3:0]  tmr_reg;
    logic [4:0]  tmr_ppi;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    priv_window_decoder u_priv_window_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .req_cpu(req_cpu),
        .irqc_rdata(irqc_rdata), .tmr_rdata(tmr_rdata), .irqc_sel(irqc_sel),
        .tmr_sel(tmr_sel), .tgt_cpu(tgt_cpu), .sub_off(sub_off),
        .tmr_idx(tmr_idx), .tmr_reg(tmr_reg), .tmr_ppi(tmr_ppi),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge; outputs settle 1 ns later.
    task automatic drive(input logic rd, input logic wr, input logic [31:0] a,
                         input logic [31:0] d, input logic [1:0] cpu);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; req_cpu = cpu;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 32'h0, 32'h0, 2'd0);
    endtask

    task automatic t_reset();
        idle();
        chk("reset err", {31'b0, bus_err}, 32'h0);
        drive(1'b1, 1'b0, 32'h0, 32'h0, 2'd0);
        chk("R2 reset flag", bus_rdata, 32'h0);
    endtask

    task automatic t_ctl_flag();
        drive(1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 2'd1);
        drive(1'b1, 1'b0, 32'h0000_0000, 32'h0, 2'd1);
        chk("R2 flag set, bit0 only", bus_rdata, 32'h1);
        drive(1'b0, 1'b1, 32'hFFFF_F000, 32'hFFFF_FFFE, 2'd2);
        drive(1'b1, 1'b0, 32'h7000_0000, 32'h0, 2'd0);
        chk("R1 upper bits ignored, flag cleared", bus_rdata, 32'h0);
        drive(1'b1, 1'b0, 32'h1234_5104, 32'h0, 2'd2);
        chk("R1 upper bits alias sel", {31'b0, irqc_sel}, 32'h1);
        chk("R1 upper bits alias sub", {24'b0, sub_off}, 32'h04);
    endtask

    task automatic t_ctl_consts();
        drive(1'b1, 1'b0, 32'h004, 32'h0, 2'd0);
        chk("R3 config word", bus_rdata, 32'hF3);
        drive(1'b1, 1'b0, 32'h008, 32'h0, 2'd0);
        chk("R3 status word", bus_rdata, 32'h0);
        drive(1'b1, 1'b0, 32'h00C, 32'h0, 2'd0);
        chk("R3 invalidate reads zero", bus_rdata, 32'h0);
        drive(1'b0, 1'b1, 32'h000, 32'h1, 2'd0);
        drive(1'b0, 1'b1, 32'h00C, 32'h0, 2'd0);
        chk("R3 invalidate write no err", {31'b0, bus_err}, 32'h0);
        drive(1'b1, 1'b0, 32'h000, 32'h0, 2'd0);
        chk("R3 invalidate write keeps flag", bus_rdata, 32'h1);
    endtask

    task automatic t_ctl_err();
        drive(1'b1, 1'b0, 32'h010, 32'h0, 2'd0);
        chk("R4 bad read err", {31'b0, bus_err}, 32'h1);
        chk("R4 bad read data", bus_rdata, 32'h0);
        drive(1'b1, 1'b0, 32'h0FC, 32'h0, 2'd3);
        chk("R4 bank top err", {31'b0, bus_err}, 32'h1);
        drive(1'b0, 1'b1, 32'h004, 32'h0, 2'd0);
        chk("R4 write to config err", {31'b0, bus_err}, 32'h1);
        drive(1'b0, 1'b1, 32'h008, 32'h0, 2'd0);
        chk("R4 write to status err", {31'b0, bus_err}, 32'h1);
        drive(1'b1, 1'b0, 32'h000, 32'h0, 2'd0);
        chk("R4 good read no err", {31'b0, bus_err}, 32'h0);
    endtask

    task automatic t_irqc();
        drive(1'b1, 1'b0, 32'h1C0, 32'h0, 2'd3);
        chk("R5 alias sel", {31'b0, irqc_sel}, 32'h1);
        chk("R5 alias cpu", {30'b0, tgt_cpu}, 32'd3);
        chk("R5 alias sub", {24'b0, sub_off}, 32'hC0);
        chk("R11 irqc read data", bus_rdata, IRQC_WORD);
        drive(1'b1, 1'b0, 32'h200, 32'h0, 2'd3);
        chk("R6 first page cpu", {30'b0, tgt_cpu}, 32'd0);
        drive(1'b1, 1'b0, 32'h3FF, 32'h0, 2'd0);
        chk("R6 page1 cpu", {30'b0, tgt_cpu}, 32'd1);
        chk("R6 page1 sub", {24'b0, sub_off}, 32'hFF);
        drive(1'b0, 1'b1, 32'h480, 32'h0, 2'd0);
        chk("R6 write sel", {31'b0, irqc_sel}, 32'h1);
        chk("R6 write cpu", {30'b0, tgt_cpu}, 32'd2);
        drive(1'b1, 1'b0, 32'h5FF, 32'h0, 2'd1);
        chk("R6 last page cpu", {30'b0, tgt_cpu}, 32'd3);
        chk("R6 last page no tmr", {31'b0, tmr_sel}, 32'h0);
    endtask

    task automatic t_timer();
        drive(1'b1, 1'b0, 32'h600, 32'h0, 2'd1);
        chk("R7 alias sel", {31'b0, tmr_sel}, 32'h1);
        chk("R7 alias cpu", {30'b0, tgt_cpu}, 32'd1);
        chk("R8 alias idx", {29'b0, tmr_idx}, 32'd2);
        chk("R9 timer ppi", {27'b0, tmr_ppi}, 32'd29);
        chk("R11 timer read data", bus_rdata, TMR_WORD);
        drive(1'b1, 1'b0, 32'h62C, 32'h0, 2'd2);
        chk("R8 alias wd idx", {29'b0, tmr_idx}, 32'd5);
        chk("R8 alias wd reg", {28'b0, tmr_reg}, 32'hC);
        chk("R9 wd ppi", {27'b0, tmr_ppi}, 32'd30);
        drive(1'b0, 1'b1, 32'h700, 32'h0, 2'd3);
        chk("R7 explicit first cpu", {30'b0, tgt_cpu}, 32'd0);
        chk("R8 explicit first idx", {29'b0, tmr_idx}, 32'd0);
        drive(1'b1, 1'b0, 32'hA24, 32'h0, 2'd0);
        chk("R7 explicit last cpu", {30'b0, tgt_cpu}, 32'd3);
        chk("R8 explicit last idx", {29'b0, tmr_idx}, 32'd7);
        chk("R8 explicit last reg", {28'b0, tmr_reg}, 32'h4);
        chk("R9 cpu is idx>>1", {30'b0, tgt_cpu}, {30'b0, tmr_idx[2:1]});
    endtask

    task automatic t_hole();
        drive(1'b1, 1'b0, 32'hB00, 32'h0, 2'd0);
        chk("R10 read err", {31'b0, bus_err}, 32'h1);
        chk("R10 read zero", bus_rdata, 32'h0);
        chk("R10 read no sel", {30'b0, irqc_sel, tmr_sel}, 32'h0);
        drive(1'b1, 1'b0, 32'hFFF, 32'h0, 2'd2);
        chk("R10 top read err", {31'b0, bus_err}, 32'h1);
        drive(1'b0, 1'b1, 32'hC00, 32'h0, 2'd0);
        chk("R10 write no err", {31'b0, bus_err}, 32'h0);
        chk("R10 write no sel", {30'b0, irqc_sel, tmr_sel}, 32'h0);
        drive(1'b1, 1'b0, 32'h000, 32'h0, 2'd0);
        chk("R10 write kept flag", bus_rdata, 32'h1);
    endtask

    task automatic t_strobes();
        drive(1'b0, 1'b0, 32'h104, 32'h0, 2'd0);
        chk("R11 no read zero", bus_rdata, 32'h0);
        chk("R12 no strobe no sel", {30'b0, irqc_sel, tmr_sel}, 32'h0);
        drive(1'b0, 1'b0, 32'h640, 32'h0, 2'd0);
        chk("R12 no strobe no tmr", {31'b0, tmr_sel}, 32'h0);
        drive(1'b1, 1'b0, 32'h004, 32'h0, 2'd0);
        chk("R12 bank access no sel", {30'b0, irqc_sel, tmr_sel}, 32'h0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl_flag();
        t_ctl_consts();
        t_ctl_err();
        t_irqc();
        t_timer();
        t_hole();
        t_strobes();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule